// File: doc/BRIEF.md
# Encoder-Gated One-Revolution Integrator

This block integrates a filtered, demodulated signal over exactly one revolution of a turntable. The turntable carries a rotary encoder with two outputs: a once-per-revolution index pulse and a frequency-multiplied position pulse train. Once a host processor arms the block, it waits for an index pulse. It then adds one signed input sample on every rising edge of the position pulse train until the next index pulse arrives. At that point the running sum and the number of samples taken are copied into result registers, and a data-good flag is raised.

The host watches the data-good flag on a general-purpose input. It reads the sum and the count and then acknowledges, which returns the block to its idle state. The sum feeds a later azimuth calculation that is outside this block. At a turntable speed of 900 revolutions per minute, one window lasts about 66.7 ms.

Both encoder inputs are asynchronous to the block clock. Each passes through a two-flop synchronizer and a rising-edge detector. Any pulse that stays high for at least two clock cycles and low for at least two clock cycles between pulses is therefore seen exactly once.

Top module: `rev_integrator`

## Requirements
- R1: While reset is asserted, and right after it, `data_good_o` is 0 and both `sum_o` and `count_o` are 0.
- R2: Encoder pulses that arrive while the block is idle (not armed) have no effect: `data_good_o` stays 0, and `sum_o` and `count_o` keep their previous values.
- R3: After an arm pulse, position pulses that arrive before the first index rising edge are not added.
- R4: Inside the window, each rising edge of `tick_i` adds `sample_i` to the sum. The sample is read as 24-bit two's complement and sign-extended to the 48-bit sum.
- R5: The index rising edge that closes the window updates `sum_o` and `count_o` and sets `data_good_o`, all on the third rising clock edge after `index_i` goes high.
- R6: If the index edge that opens the window and a tick edge are detected in the same cycle, that tick's sample is included.
- R7: If the index edge that closes the window and a tick edge are detected in the same cycle, that tick's sample is excluded.
- R8: `data_good_o` stays 1 until `ack_i` is high at a clock edge, and it is 0 after that edge. `sum_o` and `count_o` keep their values after the acknowledge.
- R9: Index and tick pulses that arrive while `data_good_o` is 1 do not change `sum_o` or `count_o`.
- R10: An arm pulse given while the block is waiting, accumulating or done has no effect. An acknowledge given outside the done state has no effect.
- R11: A tick input held high for many cycles adds its sample only once.
- R12: `count_o` equals the number of samples added in the window, and it is 0 for a window with no ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Host arm request, acted on only when idle |
| ack_i | input | 1 | Host acknowledge, acted on only when done |
| index_i | input | 1 | Asynchronous once-per-revolution encoder pulse |
| tick_i | input | 1 | Asynchronous frequency-multiplied encoder pulse |
| sample_i | input | DATA_W (24) | Signed filtered sample |
| data_good_o | output | 1 | Result valid, held until acknowledged |
| sum_o | output | ACC_W (48) | Signed sum latched at window close |
| count_o | output | CNT_W (17) | Number of samples in the latched sum |

## Verification
Every encoder-driven result arrives on the third rising clock edge after the input pin goes high. That delay is two synchronizer flops plus the state or accumulator register. An acknowledge acts on the very next edge. The bench changes inputs only at falling edges and counts exact falling edges before each sample. It checks that `data_good_o` is still 0 after two edges and is 1 after the third. It then reads the sum and count only after that third edge. A sample that must be added or dropped is held stable until at least the third edge after its tick rises, so its fate depends only on the gating rules and not on sampling skew.

// File: rtl/rev_int_pkg.sv
package rev_int_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ACCUM = 2'd2,
        ST_DONE  = 2'd3
    } gate_state_e;

    typedef struct packed {
        gate_state_e state;
        logic        dg;
    } gate_regs_t;

endpackage

// File: rtl/ri_edge_sync.sv
module ri_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.sync = {r_q.sync[STAGES-2:0], async_i};
        r_d.last = r_q.sync[STAGES-1];
        rise_o   = r_q.sync[STAGES-1] & ~r_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R11: a detected edge never lasts more than one cycle
    p_single_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/ri_gate_fsm.sv
module ri_gate_fsm
    import rev_int_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic ack_i,
    input  logic idx_rise_i,
    input  logic tick_rise_i,
    output logic clr_o,
    output logic add_o,
    output logic latch_o,
    output logic data_good_o
);

    gate_regs_t r_d, r_q;
    logic       in_accum;

    always_comb begin
        r_d     = r_q;
        clr_o   = 1'b0;
        add_o   = 1'b0;
        latch_o = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (arm_i) r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (idx_rise_i) begin
                    r_d.state = ST_ACCUM;
                    clr_o     = 1'b1;
                    add_o     = tick_rise_i;
                end
            end
            ST_ACCUM: begin
                if (idx_rise_i) begin
                    r_d.state = ST_DONE;
                    r_d.dg    = 1'b1;
                    latch_o   = 1'b1;
                end else begin
                    add_o = tick_rise_i;
                end
            end
            ST_DONE: begin
                if (ack_i) begin
                    r_d.state = ST_IDLE;
                    r_d.dg    = 1'b0;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, dg: 1'b0};
        else        r_q <= r_d;
    end

    assign data_good_o = r_q.dg;
    assign in_accum    = (r_q.state == ST_ACCUM);

    // R8: flag held until acknowledged
    p_dg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_good_o && !ack_i) |=> data_good_o);

    // R8: acknowledge drops the flag on the next edge
    p_ack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_good_o && ack_i) |=> !data_good_o);

    // R3: the window only opens on an index edge
    p_open_on_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_accum) |-> $past(idx_rise_i));

    // R10: idle is left only by an arm request
    p_idle_needs_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && !arm_i) |=> (r_q.state == ST_IDLE));

    // R5: flag rises only when a window closes
    p_dg_from_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_good_o) |-> ($past(in_accum) && $past(idx_rise_i)));

endmodule

// File: rtl/ri_accum.sv
module ri_accum #(
    parameter int DATA_W = 24,
    parameter int ACC_W  = 48,
    parameter int CNT_W  = 17
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     add_i,
    input  logic                     latch_i,
    input  logic [DATA_W-1:0]        sample_i,
    output logic signed [ACC_W-1:0]  sum_o,
    output logic [CNT_W-1:0]         count_o
);

    localparam int EXT_W = ACC_W - DATA_W;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic [CNT_W-1:0]        cnt;
        logic signed [ACC_W-1:0] res;
        logic [CNT_W-1:0]        rcnt;
    } acc_regs_t;

    acc_regs_t               r_d, r_q;
    logic signed [ACC_W-1:0] sample_ext;

    assign sample_ext = {{EXT_W{sample_i[DATA_W-1]}}, sample_i};

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d.acc = add_i ? sample_ext : '0;
            r_d.cnt = add_i ? CNT_W'(1) : '0;
        end else if (add_i) begin
            r_d.acc = r_q.acc + sample_ext;
            r_d.cnt = r_q.cnt + CNT_W'(1);
        end
        if (latch_i) begin
            r_d.res  = r_q.acc;
            r_d.rcnt = r_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sum_o   = r_q.res;
    assign count_o = r_q.rcnt;

    // R12: without a tick the running count and sum stay put
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !add_i) |=> ($stable(r_q.acc) && $stable(r_q.cnt)));

    // R12: each added sample bumps the count by exactly one
    p_count_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && add_i) |=> (r_q.cnt == $past(r_q.cnt) + CNT_W'(1)));

    // R7: the closing cycle adds nothing to the latched result
    p_close_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        latch_i |=> (r_q.res == $past(r_q.acc)));

endmodule

// File: rtl/rev_integrator.sv
module rev_integrator #(
    parameter int DATA_W      = 24,
    parameter int ACC_W       = 48,
    parameter int MAX_SAMPLES = 65536,
    parameter int CNT_W       = $clog2(MAX_SAMPLES + 1),
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    arm_i,
    input  logic                    ack_i,
    input  logic                    index_i,
    input  logic                    tick_i,
    input  logic [DATA_W-1:0]       sample_i,
    output logic                    data_good_o,
    output logic signed [ACC_W-1:0] sum_o,
    output logic [CNT_W-1:0]        count_o
);

    localparam int N_CH    = 2;
    localparam int CH_IDX  = 0;
    localparam int CH_TICK = 1;

    logic [N_CH-1:0] raw;
    logic [N_CH-1:0] rise;
    logic            clr, add, latch;

    assign raw[CH_IDX]  = index_i;
    assign raw[CH_TICK] = tick_i;

    for (genvar g = 0; g < N_CH; g++) begin : g_sync
        ri_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .async_i(raw[g]),
            .rise_o (rise[g])
        );
    end

    ri_gate_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (arm_i),
        .ack_i      (ack_i),
        .idx_rise_i (rise[CH_IDX]),
        .tick_rise_i(rise[CH_TICK]),
        .clr_o      (clr),
        .add_o      (add),
        .latch_o    (latch),
        .data_good_o(data_good_o)
    );

    ri_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .add_i   (add),
        .latch_i (latch),
        .sample_i(sample_i),
        .sum_o   (sum_o),
        .count_o (count_o)
    );

    // R9: a held result does not move while the flag stays up
    p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_good_o && $past(data_good_o)) |-> ($stable(sum_o) && $stable(count_o)));

    // R2: results only change when the flag rises
    p_result_on_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sum_o) |-> $rose(data_good_o));

endmodule

// File: tb/sim_rev_integrator.sv
module sim_rev_integrator;

    localparam int DW = 24;
    localparam int AW = 48;
    localparam int CW = 17;

    typedef struct packed {
        logic s_co;
        logic e_co;
        int   n;
        int   base;
        int   step;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0,   8,      100,  3},
        '{1'b1, 1'b0,   5,     -500, 37},
        '{1'b0, 1'b1,  12,  8388607,  0},
        '{1'b1, 1'b1, 300, -8388608,  1},
        '{1'b0, 1'b0,   0,        5,  0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm_i = 1'b0, ack_i = 1'b0, index_i = 1'b0, tick_i = 1'b0;
    logic [DW-1:0] sample_i = '0;
    logic          data_good_o;
    logic [AW-1:0] sum_o;
    logic [CW-1:0] count_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rev_integrator u0 (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .ack_i(ack_i),
        .index_i(index_i), .tick_i(tick_i), .sample_i(sample_i),
        .data_good_o(data_good_o), .sum_o(sum_o), .count_o(count_o)
    );

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(int k);
        repeat (k) @(negedge clk);
    endtask

    function automatic longint sum_now();
        return longint'($signed(sum_o));
    endfunction

    task automatic tick(int val);
        sample_i = val[DW-1:0];
        tick_i = 1'b1;
        cyc(2);
        tick_i = 1'b0;
        cyc(2);
    endtask

    task automatic arm();
        arm_i = 1'b1; cyc(1); arm_i = 1'b0; cyc(3);
    endtask

    task automatic ack();
        ack_i = 1'b1; cyc(1); ack_i = 1'b0;
    endtask

    task automatic run_rev(logic s_co, logic e_co, int n, int base, int step, int tag);
        longint es = 0;
        longint held_sum;
        int     first = 0;
        for (int i = 0; i < n; i++) es += longint'(base) + longint'(i) * longint'(step);
        arm();
        tick(12345);              // R3: before the opening index
        tick(-999);
        index_i = 1'b1;
        if (s_co && n > 0) begin  // R6: coincident opening tick
            sample_i = base[DW-1:0];
            tick_i = 1'b1;
            first = 1;
        end
        cyc(2);
        index_i = 1'b0; tick_i = 1'b0;
        cyc(3);
        arm_i = 1'b1; ack_i = 1'b1; cyc(1);  // R10: ignored mid-window
        arm_i = 1'b0; ack_i = 1'b0; cyc(3);
        for (int i = first; i < n; i++) tick(base + i * step);
        index_i = 1'b1;
        if (e_co) begin           // R7: coincident closing tick
            sample_i = 24'd54321;
            tick_i = 1'b1;
        end
        cyc(2);
        check($sformatf("R5 latency low v%0d", tag), longint'(data_good_o), 0);
        index_i = 1'b0; tick_i = 1'b0;
        cyc(1);
        check($sformatf("R5 latency high v%0d", tag), longint'(data_good_o), 1);
        check($sformatf("R4/R6/R7 sum v%0d", tag), sum_now(), es);
        check($sformatf("R12 count v%0d", tag), longint'(count_o), longint'(n));
        held_sum = sum_now();
        index_i = 1'b1; tick_i = 1'b1; sample_i = 24'd77; cyc(2);
        index_i = 1'b0; tick_i = 1'b0; cyc(6);
        check($sformatf("R9 sum held v%0d", tag), sum_now(), held_sum);
        check($sformatf("R8 flag held v%0d", tag), longint'(data_good_o), 1);
        ack();
        check($sformatf("R8 flag cleared v%0d", tag), longint'(data_good_o), 0);
        index_i = 1'b1; tick_i = 1'b1; cyc(2);
        index_i = 1'b0; tick_i = 1'b0; cyc(6);
        check($sformatf("R2 idle flag v%0d", tag), longint'(data_good_o), 0);
        check($sformatf("R2 idle sum v%0d", tag), sum_now(), held_sum);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        cyc(3);
        check("R1 reset flag", longint'(data_good_o), 0);
        check("R1 reset sum", sum_now(), 0);
        rst_n = 1'b1;
        cyc(2);
        check("R1 post-reset count", longint'(count_o), 0);

        for (int v = 0; v < NV; v++)
            run_rev(VECS[v].s_co, VECS[v].e_co, VECS[v].n, VECS[v].base, VECS[v].step, v);

        // R11: tick held high for many cycles counts once
        arm();
        index_i = 1'b1; cyc(2); index_i = 1'b0; cyc(3);
        sample_i = 24'd7; tick_i = 1'b1; cyc(20); tick_i = 1'b0; cyc(2);
        index_i = 1'b1; cyc(2); index_i = 1'b0; cyc(3);
        check("R11 held tick sum", sum_now(), 7);
        check("R11 held tick count", longint'(count_o), 1);
        ack();

        // R10: acknowledge in idle does not disturb held values
        ack(); cyc(2);
        check("R10 idle ack sum", sum_now(), 7);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule